// File: doc/BRIEF.md
# Extended-Precision Interrupt Priority Arbiter

This block collects level-sensitive interrupt requests from a set of on-chip peripheral sources and picks one winner per cycle. Each source owns a 5-bit priority setting, programmed through a simple write port. Among the sources that are requesting and have a usable priority, the one with the largest 5-bit setting wins. The processor is given a 4-bit level and an exception code that names the winning source, so a handler can identify the cause without reading any status.

The 4-bit level is the winner's 5-bit setting with its least significant bit dropped. The dropped bit is not lost inside the arbiter. It still orders two sources that present the same 4-bit level, so a setting of 0x1B wins over 0x1A even though both appear as level 0xD. A level of 0 means that no request is being presented. The winner, level and code are registered outputs.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, or while reset is held, every priority setting is 0 and the outputs read level 0, code 0 and winner index 0.
- R2: The output level equals bits [4:1] of the winning source's 5-bit priority setting.
- R3: A source whose setting is 0x00 or 0x01 never wins. When no other source is eligible, the level is 0.
- R4: Among the requesting sources with settings of 0x02 or above, the source with the largest 5-bit setting wins.
- R5: When two requesting sources present the same 4-bit level, the one with the larger 5-bit setting wins. For example, 0x1B beats 0x1A and both present level 0xD.
- R6: When two requesting sources have equal 5-bit settings, the lower source index wins.
- R7: The exception code is 0x400 + n*0x20 for winning source n, and 0 when there is no winner. The code stays unchanged while the winner is unchanged.
- R8: Requests are level-sensitive. Dropping a request withdraws it, and the winner, level and code are re-evaluated on the next clock.
- R9: The outputs change on the first clock edge after the edge at which a request change or a priority write takes effect. A write therefore shows at the outputs on the second edge after it is presented.
- R10: When wrEn is high at a clock edge, wrPrio is stored as the setting of source wrIdx. No other source's setting changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Level-sensitive request, one bit per source |
| wrEn | input | 1 | Priority write strobe |
| wrIdx | input | IDX_W | Source whose priority is written |
| wrPrio | input | 5 | New 5-bit priority setting |
| irqLevel | output | 4 | Level presented to the processor, 0 means none |
| irqCode | output | CODE_W | Exception code of the winning source |
| winIdx | output | IDX_W | Index of the winning source |

## Verification
All eight priority settings are programmed once to a fixed pattern. The pattern contains the pair 0x1A/0x1B, two identical pairs, and the unusable settings 0x00 and 0x01. Request patterns are then applied from a vector table. Single requests show that the level is derived correctly. Pairs that share a 4-bit level show whether the hidden bit breaks the tie. Identical pairs show whether the lower index wins. Patterns made only of unusable sources show that such sources are suppressed. Directed tests check write latency edge by edge, the withdrawal of a request, whether a write touches any neighbouring source, and the clearing of all settings by a reset in mid-run.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W    = 5;
  localparam int LVL_W     = PRIO_W - 1;
  localparam int SLOT_MAXW = 8;

  typedef struct packed {
    logic                 prioWrite;
    logic [SLOT_MAXW-1:0] prioSlot;
    logic [PRIO_W-1:0]    prioData;
    logic                 armed;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PRIO_W-1:0] wrPrio,
  output ctrlStrobes_t      strobes
);
  logic armedQ;

  // armed goes high one cycle after reset releases, so history checks are valid
  always_ff @(posedge clk) begin
    if (!rst_n) armedQ <= 1'b0;
    else        armedQ <= 1'b1;
  end

  always_comb begin
    strobes           = '0;
    strobes.prioWrite = wrEn & rst_n;
    strobes.prioSlot  = SLOT_MAXW'(wrIdx);
    strobes.prioData  = wrPrio;
    strobes.armed     = armedQ;
  end

  // R10: a write strobe is never raised while reset is held
  assert_no_write_in_reset_R10: assert property (@(posedge clk)
    !rst_n |-> !strobes.prioWrite);
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int              NUM_SRC   = 8,
  parameter int              IDX_W     = 3,
  parameter int              CODE_W    = 12,
  parameter logic [CODE_W-1:0] CODE_BASE = 12'h400,
  parameter logic [CODE_W-1:0] CODE_STEP = 12'h020
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [CODE_W-1:0]  irqCode,
  output logic [IDX_W-1:0]   winIdx
);
  logic [PRIO_W-1:0] prioQ [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;

  // per-source priority registers and eligibility
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rst_n)
        prioQ[g] <= '0;
      else if (strobes.prioWrite && strobes.prioSlot == SLOT_MAXW'(g))
        prioQ[g] <= strobes.prioData;
    end
    assign eligible[g] = reqIn[g] && (prioQ[g][PRIO_W-1:1] != '0);
  end

  // linear scan: strictly greater replaces, so lower index keeps ties
  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  bestIdx;
  logic              bestValid;

  always_comb begin
    bestPrio  = '0;
    bestIdx   = '0;
    bestValid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!bestValid || prioQ[i] > bestPrio)) begin
        bestPrio  = prioQ[i];
        bestIdx   = IDX_W'(i);
        bestValid = 1'b1;
      end
    end
  end

  logic [CODE_W-1:0] nextCode;
  assign nextCode = bestValid ? CODE_BASE + CODE_W'(bestIdx) * CODE_STEP : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqLevel <= '0;
      irqCode  <= '0;
      winIdx   <= '0;
    end else begin
      irqLevel <= bestValid ? bestPrio[PRIO_W-1:1] : '0;
      irqCode  <= nextCode;
      winIdx   <= bestIdx;
    end
  end

  // checker-side history of requests and writes
  logic [NUM_SRC-1:0] reqD;
  logic               wrD;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqD <= '0;
      wrD  <= 1'b0;
    end else begin
      reqD <= reqIn;
      wrD  <= strobes.prioWrite;
    end
  end

  // R7: no winner means code 0, a winner means a nonzero code
  assert_code_zero_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irqLevel == '0) == (irqCode == '0));

  // R8: a presented winner was requesting on the edge that sampled it
  assert_winner_was_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.armed && irqLevel != '0 |-> reqD[winIdx]);

  // R9: with requests and settings steady, outputs hold on the next edge
  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.armed && !strobes.prioWrite && !wrD && reqIn == reqD
    |=> $stable(irqLevel) && $stable(irqCode) && $stable(winIdx));

  // R1: outputs read zero on the edge after reset
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> irqLevel == '0 && irqCode == '0 && winIdx == '0);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int                NUM_SRC   = 8,
  parameter int                CODE_W    = 12,
  parameter logic [CODE_W-1:0] CODE_BASE = 12'h400,
  parameter logic [CODE_W-1:0] CODE_STEP = 12'h020,
  localparam int               IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [PRIO_W-1:0]  wrPrio,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [CODE_W-1:0]  irqCode,
  output logic [IDX_W-1:0]   winIdx
);
  ctrlStrobes_t strobes;

  irq_arb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrPrio(wrPrio),
    .strobes(strobes)
  );

  irq_arb_datapath #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CODE_W(CODE_W),
    .CODE_BASE(CODE_BASE), .CODE_STEP(CODE_STEP)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .reqIn(reqIn),
    .irqLevel(irqLevel), .irqCode(irqCode), .winIdx(winIdx)
  );
endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqIn = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrIdx = '0;
  logic [4:0] wrPrio = '0;
  logic [3:0] irqLevel;
  logic [11:0] irqCode;
  logic [2:0] winIdx;

  int applied = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  irq_prio_arbiter u_irq_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrPrio(wrPrio), .irqLevel(irqLevel), .irqCode(irqCode), .winIdx(winIdx)
  );

  // entry: {req[15:8], level[7:4], idx[3:1], valid[0]}, plus requirement tag
  localparam int NVEC = 11;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'b0000_0001, 4'h0, 3'd0, 1'b0},  // R3 setting 0x01 alone
    {8'b0010_0001, 4'h0, 3'd0, 1'b0},  // R3 settings 0x00 and 0x01
    {8'b0000_0010, 4'hD, 3'd1, 1'b1},  // R2 0x1A alone
    {8'b0000_0110, 4'hD, 3'd2, 1'b1},  // R5 0x1B beats 0x1A
    {8'b0001_1000, 4'h8, 3'd3, 1'b1},  // R6 equal 0x10 pair
    {8'b1000_0100, 4'hD, 3'd2, 1'b1},  // R6 equal 0x1B pair
    {8'b1000_0000, 4'hD, 3'd7, 1'b1},  // R7 code of top source
    {8'b0100_1000, 4'h8, 3'd3, 1'b1},  // R4 0x10 over 0x05
    {8'b0100_0000, 4'h2, 3'd6, 1'b1},  // R2 0x05 alone
    {8'b1111_1111, 4'hD, 3'd2, 1'b1},  // R4 all pending
    {8'b0000_0000, 4'h0, 3'd0, 1'b0}   // R8 nothing pending
  };
  localparam int VTAG [NVEC] = '{3, 3, 2, 5, 6, 6, 7, 4, 2, 4, 8};

  function automatic logic [11:0] codeOf(input logic valid, input logic [2:0] idx);
    return valid ? 12'h400 + {9'd0, idx} * 12'h020 : 12'h000;
  endfunction

  task automatic check(input string tag, input logic [3:0] lvl,
                       input logic [2:0] idx, input logic valid);
    logic [11:0] code = codeOf(valid, idx);
    applied++;
    if (irqLevel !== lvl || irqCode !== code || (valid && winIdx !== idx)) begin
      miscompares++;
      $display("FAIL %s: level=%h code=%h idx=%0d expected level=%h code=%h idx=%0d",
               tag, irqLevel, irqCode, winIdx, lvl, code, idx);
    end
  endtask

  task automatic writePrio(input logic [2:0] idx, input logic [4:0] p);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrPrio = p;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic applyReq(input logic [7:0] r);
    @(negedge clk);
    reqIn = r;
    @(posedge clk); #1;
  endtask

  localparam logic [4:0] PRIOS [8] = '{5'h01, 5'h1A, 5'h1B, 5'h10, 5'h10, 5'h00, 5'h05, 5'h1B};

  initial begin : watchdog
    #400000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 4'h0, 3'd0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1: settings are zero after reset, so a full request presents nothing
    applyReq(8'hFF);
    check("R1 zero settings", 4'h0, 3'd0, 1'b0);
    applyReq(8'h00);

    for (int s = 0; s < 8; s++) writePrio(3'(s), PRIOS[s]);
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      applyReq(VEC[v][15:8]);
      check($sformatf("R%0d vec%0d", VTAG[v], v), VEC[v][7:4], VEC[v][3:1], VEC[v][0]);
    end

    // R9: write presented before edge A shows only at edge B
    applyReq(8'b0000_0010);
    check("R9 before write", 4'hD, 3'd1, 1'b1);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd1; wrPrio = 5'h06;
    @(posedge clk); #1;
    wrEn = 1'b0;
    check("R9 one edge after write", 4'hD, 3'd1, 1'b1);
    @(posedge clk); #1;
    check("R9 two edges after write", 4'h3, 3'd1, 1'b1);

    // R8: withdraw the request, next edge shows none
    applyReq(8'b0000_0000);
    check("R8 withdrawn", 4'h0, 3'd0, 1'b0);
    // R8: re-evaluation to next winner when top source leaves
    applyReq(8'b0000_0110);
    check("R8 pair", 4'hD, 3'd2, 1'b1);
    applyReq(8'b0000_0010);
    check("R8 after drop", 4'h3, 3'd1, 1'b1);

    // R10: rewrite src3 to 0x1F; src4 keeps 0x10
    writePrio(3'd3, 5'h1F);
    applyReq(8'b0001_0000);
    check("R10 neighbour kept", 4'h8, 3'd4, 1'b1);
    applyReq(8'b0001_1000);
    check("R10 written value", 4'hF, 3'd3, 1'b1);

    // R3: reprogramming a source to 0x01 removes it
    writePrio(3'd3, 5'h01);
    applyReq(8'b0000_1000);
    check("R3 set to 0x01", 4'h0, 3'd0, 1'b0);

    // R1: mid-run reset clears outputs and settings
    applyReq(8'b1000_0000);
    check("R1 pre-reset", 4'hD, 3'd7, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 in reset", 4'h0, 3'd0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    applyReq(8'hFF);
    check("R1 settings cleared", 4'h0, 3'd0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule